// File: doc/BRIEF.md
# Eight-Pin Register-Controlled Port with Edge Interrupt

The block controls eight general-purpose pins through four internal byte registers. Two mode registers choose, pin by pin, between an open-drain driver, a push-pull driver and a released (input-only) pin. A level register holds the output bits the drivers use. Reading that same register returns the levels actually present on the pins, after a two-flop synchronizer, and not the bits that were written. The synchronizer depth is a parameter; the default is two.

One pin, chosen by a parameter (pin 0 by default), can raise an interrupt. When the interrupt is enabled and the chosen edge is seen on the synchronized level of that pin, a sticky flag is set and the active-low `irq_n` output goes low. Reading the edge register returns the flag and clears it. A software handler reads the edge register, acts on the event and leaves `irq_n` released.

The register port uses plain strobes and has no back-pressure. Every cycle it accepts one write, one read, or one of each. Read data is registered and appears in the cycle after the read strobe. Each pin is modelled as three signals: an output value, an output enable and a sampled input.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset all four registers read 0. Every pin is then in open-drain mode with output bit 0, so `pin_oe` is 8'hFF, `pin_out` is 8'h00 and `irq_n` is 1.
- R2: Pin k (k = 0..3) takes its mode from bits [2k+1:2k] of the register at address 0. Pin k (k = 4..7) takes its mode from bits [2(k-4)+1:2(k-4)] of the register at address 1.
- R3: Mode 2'b00 is open-drain. The pin is driven low (`pin_oe`=1, `pin_out`=0) when its output bit is 0. It is released (`pin_oe`=0, `pin_out`=0) when its output bit is 1.
- R4: Mode 2'b10 is push-pull. `pin_oe`=1 and `pin_out` equals the output bit.
- R5: Mode 2'b01 (input only) and mode 2'b11 (reserved) release the pin: `pin_oe`=0 and `pin_out`=0.
- R6: A write to address 2 sets the eight output bits. A read of address 2 returns `pin_in` as sampled two clock edges earlier, whatever was written.
- R7: The registers at addresses 0 and 1 read back the value last written. Address 3 reads as {5'b0, flag, select, enable}, with enable in bit 0, edge select in bit 1 and the flag in bit 2. Read data is valid from the cycle after the read strobe.
- R8: With enable set, select = 0 makes a 0-to-1 transition on the interrupt pin set the flag, and select = 1 makes a 1-to-0 transition set it. `irq_n` is the inverse of the flag.
- R9: The flag is not set when enable is 0, when the transition has the other direction, or when the transition is on any pin other than the interrupt pin.
- R10: A read of address 3 returns the flag as it was before the read and then clears it. A write to address 3 changes only enable and select; bit 2 of the write data has no effect on the flag.
- R11: If a qualifying edge is detected in the same cycle as a clearing read, the flag ends up set and `irq_n` stays or goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The two functions that can land in the same cycle are the set of the interrupt flag by a detected edge and its clear by a read of the edge register. The bench counts the synchronizer and edge-detector registers so that its read strobe is sampled on exactly the edge at which the detector fires. The read data must then show the flag's earlier value, and `irq_n` must be low afterwards. The case is run both with the flag already set and with the flag clear.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [1:0] {
    PM_OPEN_DRAIN = 2'b00,
    PM_INPUT      = 2'b01,
    PM_PUSH_PULL  = 2'b10,
    PM_RESERVED   = 2'b11
  } pin_mode_e;

  localparam logic [1:0] RA_MODE_LO = 2'd0;
  localparam logic [1:0] RA_MODE_HI = 2'd1;
  localparam logic [1:0] RA_LEVEL   = 2'd2;
  localparam logic [1:0] RA_EDGE    = 2'd3;

  localparam int EB_EN   = 0;
  localparam int EB_SEL  = 1;
  localparam int EB_FLAG = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_drive.sv
module gpio_drive
  import gpio_edge_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic [2*NPIN-1:0] mode_vec_i,
  input  logic [NPIN-1:0]   out_bits_i,
  output logic [NPIN-1:0]   pin_out_o,
  output logic [NPIN-1:0]   pin_oe_o
);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pin_mode_e mode;
    assign mode = pin_mode_e'(mode_vec_i[2*i +: 2]);

    always_comb begin
      pin_out_o[i] = 1'b0;
      pin_oe_o[i]  = 1'b0;
      case (mode)
        PM_OPEN_DRAIN: pin_oe_o[i] = ~out_bits_i[i];
        PM_PUSH_PULL: begin
          pin_oe_o[i]  = 1'b1;
          pin_out_o[i] = out_bits_i[i];
        end
        default: begin
          pin_oe_o[i]  = 1'b0;
          pin_out_o[i] = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic en_i,
  input  logic sel_i,
  input  logic clr_i,
  output logic flag_o
);

  logic prev_q;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  // select 0: rising, select 1: falling
  assign hit = en_i & (sel_i ? (prev_q & ~level_i) : (~prev_q & level_i));

  // set has priority over the clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (hit)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !sel_i && !prev_q && level_i) |=> flag_o); // R8

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !flag_o) |=> !flag_o); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit) |=> !flag_o); // R10

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && hit) |=> flag_o); // R11

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int DW          = 8,
  parameter int ADDR_W      = 2,
  parameter int IRQ_PIN     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DW-1:0]     reg_rdata,
  input  logic [DW-1:0]     pin_in,
  output logic [DW-1:0]     pin_out,
  output logic [DW-1:0]     pin_oe,
  output logic              irq_n
);

  localparam int NPIN = DW;

  logic [DW-1:0]     mode_lo_q, mode_hi_q, level_q;
  logic              en_q, sel_q, flag;
  logic [DW-1:0]     pin_sync;
  logic [2*NPIN-1:0] mode_vec;
  logic              sel_lo, sel_hi, sel_lvl, sel_edge;

  assign sel_lo   = (reg_addr == ADDR_W'(RA_MODE_LO));
  assign sel_hi   = (reg_addr == ADDR_W'(RA_MODE_HI));
  assign sel_lvl  = (reg_addr == ADDR_W'(RA_LEVEL));
  assign sel_edge = (reg_addr == ADDR_W'(RA_EDGE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lo_q <= '0;
      mode_hi_q <= '0;
      level_q   <= '0;
      en_q      <= 1'b0;
      sel_q     <= 1'b0;
    end else if (reg_wr) begin
      if (sel_lo)  mode_lo_q <= reg_wdata;
      if (sel_hi)  mode_hi_q <= reg_wdata;
      if (sel_lvl) level_q   <= reg_wdata;
      if (sel_edge) begin
        en_q  <= reg_wdata[EB_EN];
        sel_q <= reg_wdata[EB_SEL];
      end
    end
  end

  gpio_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_in),
    .q_o  (pin_sync)
  );

  assign mode_vec = {mode_hi_q, mode_lo_q};

  gpio_drive #(.NPIN(NPIN)) u_drive (
    .mode_vec_i(mode_vec),
    .out_bits_i(level_q),
    .pin_out_o (pin_out),
    .pin_oe_o  (pin_oe)
  );

  gpio_edge_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i(pin_sync[IRQ_PIN]),
    .en_i   (en_q),
    .sel_i  (sel_q),
    .clr_i  (reg_rd && sel_edge),
    .flag_o (flag)
  );

  assign irq_n = ~flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (1'b1)
        sel_lo:   reg_rdata <= mode_lo_q;
        sel_hi:   reg_rdata <= mode_hi_q;
        sel_lvl:  reg_rdata <= pin_sync;
        sel_edge: reg_rdata <= {{(DW-3){1'b0}}, flag, sel_q, en_q};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    logic [1:0] m;
    assign m = mode_vec[2*i +: 2];

    AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (m[0] == 1'b1) |-> (!pin_oe[i] && !pin_out[i])); // R5

    AST_PUSH_PULL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b10) |-> (pin_oe[i] && pin_out[i] == level_q[i])); // R4

    AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b00) |-> (!pin_out[i] && pin_oe[i] == !level_q[i])); // R3
  end

endmodule

// File: tb/tb_gpio_edge_port.sv
`timescale 1ns/1ps
module tb_gpio_edge_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic       irq_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_edge_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] mode_of(input int i, input logic [7:0] c0, input logic [7:0] c1);
    logic [7:0] c;
    c = (i < 4) ? c0 : c1;
    return 2'((c >> (2 * (i % 4))) & 8'h3);
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] eo, ee;
    logic [7:0] pats [3];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", pin_oe, 8'hFF);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg", d, 8'h00);
    end

    // R2..R5 sweep: one pin at a time in each mode, others input-only
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] c0, c1;
        c0 = 8'h55; c1 = 8'h55;
        if (p < 4) c0 = (c0 & ~(8'h3 << (2 * p))) | 8'(m << (2 * p));
        else       c1 = (c1 & ~(8'h3 << (2 * (p - 4)))) | 8'(m << (2 * (p - 4)));
        wr(2'd0, c0);
        wr(2'd1, c1);
        for (int k = 0; k < 3; k++) begin
          wr(2'd2, pats[k]);
          for (int i = 0; i < 8; i++) begin
            logic [1:0] mi;
            mi = mode_of(i, c0, c1);
            eo[i] = (mi == 2'b10) ? pats[k][i] : 1'b0;
            ee[i] = (mi == 2'b10) ? 1'b1 : (mi == 2'b00) ? ~pats[k][i] : 1'b0;
          end
          if (m == 0)      begin chk("R2 R3 oe", pin_oe, ee); chk("R3 out", pin_out, eo); end
          else if (m == 2) begin chk("R2 R4 oe", pin_oe, ee); chk("R4 out", pin_out, eo); end
          else             begin chk("R2 R5 oe", pin_oe, ee); chk("R5 out", pin_out, eo); end
        end
      end
    end

    // R7 config readback
    wr(2'd0, 8'h93); wr(2'd1, 8'h6C);
    rd(2'd0, d); chk("R7 mode lo", d, 8'h93);
    rd(2'd1, d); chk("R7 mode hi", d, 8'h6C);
    wr(2'd0, 8'h55); wr(2'd1, 8'h55);

    // R6 readback latency: read sampled at edges 1 and 2 sees old, edge 3 new
    wr(2'd2, 8'h00);
    @(negedge clk);
    pin_in = 8'h3C;
    reg_addr = 2'd2; reg_rd = 1'b1;
    @(negedge clk); chk("R6 lat1", reg_rdata, 8'h00);
    @(negedge clk); chk("R6 lat2", reg_rdata, 8'h00);
    @(negedge clk); chk("R6 lat3", reg_rdata, 8'h3C);
    reg_rd = 1'b0;

    // R6 exhaustive readback, written value differs
    wr(2'd2, 8'hA5);
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      pin_in = 8'(v);
      settle(2);
      rd(2'd2, d);
      chk("R6 level", d, 8'(v));
    end

    // Interrupt tests on pin 0
    pin_in = 8'h00; settle(4);
    wr(2'd3, 8'h01);
    rd(2'd3, d); chk("R7 edge reg", d, 8'h01);
    pin_in = 8'h01; settle(4);
    chk("R8 rise irq", {7'b0, irq_n}, 8'h00);
    wr(2'd3, 8'h01);
    chk("R10 write keeps flag", {7'b0, irq_n}, 8'h00);
    rd(2'd3, d); chk("R10 read returns flag", d, 8'h05);
    chk("R10 cleared irq", {7'b0, irq_n}, 8'h01);
    rd(2'd3, d); chk("R10 flag gone", d, 8'h01);

    pin_in = 8'h00; settle(4);
    chk("R9 wrong edge", {7'b0, irq_n}, 8'h01);
    pin_in = 8'hFE; settle(4);
    chk("R9 other pins", {7'b0, irq_n}, 8'h01);
    pin_in = 8'h00; settle(4);

    wr(2'd3, 8'h07);
    rd(2'd3, d); chk("R10 flag bit not writable", d, 8'h03);
    pin_in = 8'h01; settle(4);
    chk("R9 rise with falling select", {7'b0, irq_n}, 8'h01);
    pin_in = 8'h00; settle(4);
    chk("R8 fall irq", {7'b0, irq_n}, 8'h00);
    rd(2'd3, d); chk("R8 fall flag", d, 8'h07);

    wr(2'd3, 8'h00);
    pin_in = 8'h01; settle(4);
    pin_in = 8'h00; settle(4);
    chk("R9 disabled", {7'b0, irq_n}, 8'h01);
    rd(2'd3, d); chk("R9 disabled reg", d, 8'h00);

    // R11 coincident edge and clearing read, flag clear beforehand
    wr(2'd3, 8'h01);
    @(negedge clk);
    pin_in = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_addr = 2'd3; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R11 read before set", reg_rdata, 8'h01);
    chk("R11 irq after", {7'b0, irq_n}, 8'h00);
    rd(2'd3, d); chk("R11 flag kept", d, 8'h05);

    // R11 coincident, flag already set
    pin_in = 8'h00; settle(4);
    pin_in = 8'h01; settle(4);
    pin_in = 8'h00; settle(4);
    @(negedge clk);
    pin_in = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_addr = 2'd3; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R11 preset read", reg_rdata, 8'h05);
    chk("R11 preset irq", {7'b0, irq_n}, 8'h00);
    rd(2'd3, d); chk("R11 preset final", d, 8'h05);
    chk("R10 final clear", {7'b0, irq_n}, 8'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule